// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This block works out where a 16-bit processor fetches next after a control-flow instruction. It covers the conditional branch on the N/Z/P result flags, the register jump (and its return form through R7), the two forms of subroutine call (PC-relative and through a register), and the trap. The pipeline gives it the instruction word, the program counter that has already been incremented past that instruction, and the current flags. The block drives a register-file read index and receives the base register contents back in the same cycle. For traps it also has a single memory read port into the vector table.

One request is made by pulsing `start`. The block has two states. In `ST_IDLE` it accepts requests. A trap request takes the transition IDLE→VEC_WAIT: the vector-table read is issued in the request cycle and the block waits one cycle for the word. Every other request stays on the transition IDLE→IDLE and completes at once. The transition VEC_WAIT→IDLE always happens after exactly one cycle. Each result is presented with a one-cycle `done` pulse. The pulse comes with `next_pc` and, for calls and traps, a write of the return address into R7 (`link_we`/`link_data`).

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `link_we` and `mem_req` are 0 and `next_pc` is 0 until the first request completes.
- R2: A branch has opcode 0000, with bit 11 selecting N, bit 10 selecting Z and bit 9 selecting P. It is taken when any selected bit is also set in `flags_nzp` ({N,Z,P}). The target is `pc_inc` plus the sign-extended field [8:0], wrapping modulo 2^16. `done` rises one cycle after `start`.
- R3: A branch with no selected flag set among the current ones, or with bits 11..9 all zero, yields `next_pc` = `pc_inc`.
- R4: A jump has opcode 1100. `base_idx` carries bits [8:6], and `next_pc` equals the base register contents. With index 7 this is the return.
- R5: A call with opcode 0100 and bit 11 set targets `pc_inc` plus the sign-extended field [10:0`]`. It raises `link_we` with `link_data` = `pc_inc`.
- R6: A call with opcode 0100 and bit 11 clear targets the base register [8:6]. It raises `link_we` with `link_data` = `pc_inc`. When the base is R7, the target is the R7 value from before the link write.
- R7: A trap has opcode 1111. In the request cycle it raises `mem_req` with `mem_addr` = zero-extended bits [7:0]. It takes the word read back (returned one cycle later) as `next_pc`. `done` comes two cycles after `start`, together with `link_we` and `link_data` = `pc_inc`.
- R8: Any other opcode yields `next_pc` = `pc_inc` with `link_we` low, one cycle after `start`.
- R9: `start` is ignored while a trap read is pending. `link_we` is never high without `done`, and `done` is low in the cycle after a trap request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe for the instruction on `instr` |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Program counter already incremented past the instruction |
| flags_nzp | input | 3 | Current flags {N,Z,P} |
| base_idx | output | 3 | Register-file read index (bits [8:6]) |
| base_data | input | 16 | Contents of register `base_idx`, same cycle |
| mem_req | output | 1 | Vector-table read request |
| mem_addr | output | 16 | Vector-table read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_req` |
| next_pc | output | 16 | Computed next program counter |
| done | output | 1 | One-cycle result strobe |
| link_we | output | 1 | Write `link_data` into R7 |
| link_data | output | 16 | Return address for R7 |

## Verification
Branch, jump, call and other requests raise `done` at the first clock edge after the `start` edge. A trap raises it one edge later, and its `mem_req`/`mem_addr` are combinational in the request cycle. The bench therefore drives on falling edges and probes `mem_req` shortly after driving. It reads `done`, `next_pc` and the link outputs on the falling edge one cycle after `start` for fast requests, or two cycles after for traps. It first confirms that `done` is still low on the intermediate falling edge. Its memory model answers one cycle after the request, so the trap latency is checked against a real one-cycle read.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam logic [3:0] OP_BR   = 4'b0000;
    localparam logic [3:0] OP_CALL = 4'b0100;
    localparam logic [3:0] OP_JMP  = 4'b1100;
    localparam logic [3:0] OP_TRAP = 4'b1111;

    typedef enum logic {
        ST_IDLE,
        ST_VEC_WAIT
    } npc_state_e;

    typedef enum logic [2:0] {
        K_BR,
        K_JMP,
        K_CALL_REL,
        K_CALL_REG,
        K_TRAP,
        K_OTHER
    } npc_kind_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] instr,
    output npc_kind_e    kind,
    output logic [2:0]   cond_mask,
    output logic [2:0]   base_idx,
    output logic [W-1:0] off_short,
    output logic [W-1:0] off_long,
    output logic [7:0]   vec
);
    localparam int SHORT_BITS = 9;
    localparam int LONG_BITS  = 11;
    localparam int VEC_BITS   = 8;

    logic [3:0] opcode;

    assign opcode    = instr[15:12];
    assign cond_mask = instr[11:9];
    assign base_idx  = instr[8:6];
    assign vec       = instr[VEC_BITS-1:0];
    assign off_short = {{(W-SHORT_BITS){instr[SHORT_BITS-1]}}, instr[SHORT_BITS-1:0]};
    assign off_long  = {{(W-LONG_BITS){instr[LONG_BITS-1]}}, instr[LONG_BITS-1:0]};

    always_comb begin
        unique case (opcode)
            OP_BR:   kind = K_BR;
            OP_JMP:  kind = K_JMP;
            OP_CALL: kind = instr[11] ? K_CALL_REL : K_CALL_REG;
            OP_TRAP: kind = K_TRAP;
            default: kind = K_OTHER;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int W = 16
) (
    input  npc_kind_e    kind,
    input  logic [2:0]   cond_mask,
    input  logic [2:0]   flags_nzp,
    input  logic [W-1:0] pc_inc,
    input  logic [W-1:0] base_data,
    input  logic [W-1:0] off_short,
    input  logic [W-1:0] off_long,
    output logic [W-1:0] tgt_pc,
    output logic         want_link,
    output logic         is_trap
);
    logic         taken;
    logic [W-1:0] rel_short;
    logic [W-1:0] rel_long;

    assign taken     = |(cond_mask & flags_nzp);
    assign rel_short = pc_inc + off_short;
    assign rel_long  = pc_inc + off_long;

    always_comb begin
        tgt_pc    = pc_inc;
        want_link = 1'b0;
        is_trap   = 1'b0;
        unique case (kind)
            K_BR:       tgt_pc = taken ? rel_short : pc_inc;
            K_JMP:      tgt_pc = base_data;
            K_CALL_REL: begin
                tgt_pc    = rel_long;
                want_link = 1'b1;
            end
            K_CALL_REG: begin
                tgt_pc    = base_data;
                want_link = 1'b1;
            end
            K_TRAP: begin
                want_link = 1'b1;
                is_trap   = 1'b1;
            end
            default:    tgt_pc = pc_inc;
        endcase
    end
endmodule

// File: rtl/npc_fsm.sv
module npc_fsm
    import npc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_trap,
    input  logic         want_link,
    input  logic [W-1:0] tgt_pc,
    input  logic [W-1:0] pc_inc,
    input  logic [W-1:0] mem_rdata,
    output logic         busy,
    output logic         mem_req,
    output logic [W-1:0] next_pc,
    output logic         done,
    output logic         link_we,
    output logic [W-1:0] link_data
);
    npc_state_e   state, state_nx;
    logic [W-1:0] ret_q;

    assign busy    = (state == ST_VEC_WAIT);
    assign mem_req = (state == ST_IDLE) && start && is_trap;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start && is_trap) state_nx = ST_VEC_WAIT;
            ST_VEC_WAIT: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc   <= '0;
            done      <= 1'b0;
            link_we   <= 1'b0;
            link_data <= '0;
            ret_q     <= '0;
        end else begin
            done    <= 1'b0;
            link_we <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start && is_trap) begin
                        ret_q <= pc_inc;
                    end else if (start) begin
                        done      <= 1'b1;
                        next_pc   <= tgt_pc;
                        link_we   <= want_link;
                        link_data <= pc_inc;
                    end
                end
                ST_VEC_WAIT: begin
                    done      <= 1'b1;
                    next_pc   <= mem_rdata;
                    link_we   <= 1'b1;
                    link_data <= ret_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] pc_inc,
    input  logic [2:0]   flags_nzp,
    output logic [2:0]   base_idx,
    input  logic [W-1:0] base_data,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] next_pc,
    output logic         done,
    output logic         link_we,
    output logic [W-1:0] link_data
);
    npc_kind_e    kind;
    logic [2:0]   cond_mask;
    logic [W-1:0] off_short;
    logic [W-1:0] off_long;
    logic [7:0]   vec;
    logic [W-1:0] tgt_pc;
    logic         want_link;
    logic         is_trap;
    logic         fsm_busy;

    assign mem_addr = {{(W-8){1'b0}}, vec};

    npc_decode #(.W(W)) decode_i (
        .instr     (instr),
        .kind      (kind),
        .cond_mask (cond_mask),
        .base_idx  (base_idx),
        .off_short (off_short),
        .off_long  (off_long),
        .vec       (vec)
    );

    npc_target #(.W(W)) target_i (
        .kind      (kind),
        .cond_mask (cond_mask),
        .flags_nzp (flags_nzp),
        .pc_inc    (pc_inc),
        .base_data (base_data),
        .off_short (off_short),
        .off_long  (off_long),
        .tgt_pc    (tgt_pc),
        .want_link (want_link),
        .is_trap   (is_trap)
    );

    npc_fsm #(.W(W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_trap   (is_trap),
        .want_link (want_link),
        .tgt_pc    (tgt_pc),
        .pc_inc    (pc_inc),
        .mem_rdata (mem_rdata),
        .busy      (fsm_busy),
        .mem_req   (mem_req),
        .next_pc   (next_pc),
        .done      (done),
        .link_we   (link_we),
        .link_data (link_data)
    );
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic mem_req,
    input logic done,
    input logic link_we
);
    p_link_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> done);

    p_no_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_req);

    p_wait_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_req_enters_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> busy);

    p_trap_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !done ##1 done);

    p_fast_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !mem_req) |=> done);
endmodule

bind npc_unit npc_unit_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (fsm_busy),
    .mem_req (mem_req),
    .done    (done),
    .link_we (link_we)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_inc = '0;
    logic [2:0]  flags_nzp = '0;
    logic [2:0]  base_idx;
    logic [15:0] base_data;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [15:0] next_pc;
    logic        done;
    logic        link_we;
    logic [15:0] link_data;

    logic [15:0] rf [8];
    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign base_data = rf[base_idx];

    function automatic logic [15:0] vec_word(input logic [7:0] a);
        return {a ^ 8'h40, ~a};
    endfunction

    always_ff @(posedge clk) begin
        if (mem_req) mem_rdata <= vec_word(mem_addr[7:0]);
    end

    npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_inc(pc_inc),
        .flags_nzp(flags_nzp), .base_idx(base_idx), .base_data(base_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .next_pc(next_pc), .done(done), .link_we(link_we), .link_data(link_data)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [15:0] ins, input logic [15:0] pc,
                           input logic [2:0] fl, input bit trap, input logic [15:0] exp_pc,
                           input bit exp_link);
        @(negedge clk);
        instr = ins; pc_inc = pc; flags_nzp = fl; start = 1'b1;
        #1;
        check(mem_req == trap, req, {15'd0, mem_req}, {15'd0, trap});
        if (trap) check(mem_addr == {8'h00, ins[7:0]}, req, mem_addr, {8'h00, ins[7:0]});
        @(negedge clk);
        start = 1'b0;
        if (trap) begin
            check(done == 1'b0, req, {15'd0, done}, 16'd0);
            @(negedge clk);
        end
        check(done == 1'b1, req, {15'd0, done}, 16'd1);
        check(next_pc == exp_pc, req, next_pc, exp_pc);
        check(link_we == exp_link, req, {15'd0, link_we}, {15'd0, exp_link});
        if (exp_link) begin
            check(link_data == pc, req, link_data, pc);
            rf[7] = link_data;
        end
        @(negedge clk);
        check(done == 1'b0, req, {15'd0, done}, 16'd0);
    endtask

    task automatic t_reset();
        // R1
        @(negedge clk);
        check(done == 1'b0 && link_we == 1'b0, "R1", {14'd0, done, link_we}, 16'd0);
        check(next_pc == 16'h0000, "R1", next_pc, 16'h0000);
        check(mem_req == 1'b0, "R1", {15'd0, mem_req}, 16'd0);
    endtask

    task automatic t_branch();
        run_one("R2", 16'h0900, 16'h3001, 3'b100, 1'b0, 16'h2F01, 1'b0);
        run_one("R2", 16'h02FF, 16'h3001, 3'b001, 1'b0, 16'h3100, 1'b0);
        run_one("R2", 16'h0E20, 16'hFFF0, 3'b010, 1'b0, 16'h0010, 1'b0);
        run_one("R3", 16'h0805, 16'h4000, 3'b010, 1'b0, 16'h4000, 1'b0);
        run_one("R3", 16'h0033, 16'h4000, 3'b111, 1'b0, 16'h4000, 1'b0);
    endtask

    task automatic t_jump();
        rf[3] = 16'hABCD;
        run_one("R4", 16'hC0C0, 16'h1000, 3'b000, 1'b0, 16'hABCD, 1'b0);
        rf[7] = 16'h7777;
        run_one("R4", 16'hC1C0, 16'h1000, 3'b000, 1'b0, 16'h7777, 1'b0);
    endtask

    task automatic t_call_rel();
        run_one("R5", 16'h4C00, 16'h5000, 3'b000, 1'b0, 16'h4C00, 1'b1);
        run_one("R5", 16'h4BFF, 16'h5000, 3'b000, 1'b0, 16'h53FF, 1'b1);
    endtask

    task automatic t_call_reg();
        rf[2] = 16'h2222;
        run_one("R6", 16'h4080, 16'h6000, 3'b000, 1'b0, 16'h2222, 1'b1);
        rf[7] = 16'h1234;
        run_one("R6", 16'h41C0, 16'h6100, 3'b000, 1'b0, 16'h1234, 1'b1);
        check(rf[7] == 16'h6100, "R6", rf[7], 16'h6100);
    endtask

    task automatic t_trap();
        run_one("R7", 16'hF025, 16'h7000, 3'b000, 1'b1, vec_word(8'h25), 1'b1);
        run_one("R7", 16'hF0FF, 16'h7100, 3'b000, 1'b1, vec_word(8'hFF), 1'b1);
    endtask

    task automatic t_other();
        run_one("R8", 16'h1283, 16'h8000, 3'b111, 1'b0, 16'h8000, 1'b0);
        run_one("R8", 16'hE1FF, 16'h8001, 3'b001, 1'b0, 16'h8001, 1'b0);
    endtask

    task automatic t_busy_ignore();
        // R9: a jump presented while the trap read is pending has no effect
        rf[1] = 16'h9999;
        @(negedge clk);
        instr = 16'hF030; pc_inc = 16'h9000; start = 1'b1;
        @(negedge clk);
        instr = 16'hC040; pc_inc = 16'h9500;
        #1;
        check(mem_req == 1'b0, "R9", {15'd0, mem_req}, 16'd0);
        check(done == 1'b0, "R9", {15'd0, done}, 16'd0);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R9", {15'd0, done}, 16'd1);
        check(next_pc == vec_word(8'h30), "R9", next_pc, vec_word(8'h30));
        check(link_data == 16'h9000, "R9", link_data, 16'h9000);
        @(negedge clk);
        check(done == 1'b0 && link_we == 1'b0, "R9", {14'd0, done, link_we}, 16'd0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 16'(i * 16'h0111);
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_branch();
        t_jump();
        t_call_rel();
        t_call_reg();
        t_trap();
        t_other();
        t_busy_ignore();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule